// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address for every beat of a read or write burst in a four-bank, 32-bit synchronous DRAM model or controller. A command supplies a start column, a bank and a read/write flag. The block takes the burst length code and the single-write option from the mode inputs at that moment. On each following clock it presents one column address, holds the bank, and marks the final beat of a fixed-length burst.

Fixed bursts of 2, 4 or 8 beats count upward and wrap inside the aligned group of that size. A full-page burst walks all 512 columns with wraparound and stops only when a stop pulse or a new command arrives. A new command may land on any cycle and restarts the sequence at once. A reserved length code starts no burst and raises an error flag.

Top module: `burst_col_gen`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `beat_valid`, `last_beat` and `mode_err` are 0 and `col_out` is 0.
- R2: A command (`cmd_valid`=1) with a legal length code, sampled at edge n, gives `beat_valid`=1, `col_out`=`cmd_col` and `bank_out`=`cmd_bank` after edge n.
- R3: The length code `mode_bl` maps as 000→1 beat, 001→2, 010→4, 011→8, 111→full page. A fixed burst shows exactly that many beats, and `beat_valid` is 0 in the cycle after the last beat.
- R4: Beat k of a fixed burst of length L starting at column s has the address (s with its low log2(L) bits cleared) OR ((s+k) mod L).
- R5: A full-page burst steps the column by one, modulo 512. It continues until a stop or a new command ends it, and it never raises `last_beat`.
- R6: `last_beat` is 1 only during the final beat of a fixed-length burst.
- R7: With `mode_wr_single`=1, a write command (`cmd_write`=1) gives one beat whatever the length code. Reads still use the programmed length. With `mode_wr_single`=0, writes use the programmed length.
- R8: A new command cuts off a running burst on any cycle and starts its own sequence in the next cycle. When `cmd_valid` and `burst_stop` arrive together, the command wins.
- R9: `burst_stop` ends an active burst, so `beat_valid` is 0 after that edge. While the block is idle the pulse has no effect.
- R10: The codes 100, 101 and 110 are reserved, for reads and writes alike. A command carrying one of them ends any burst and starts none, and it sets `mode_err`=1 after that edge. `mode_err` stays 1 until a command with a legal code clears it.
- R11: `bank_out` stays constant for every beat of a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | New read or write command this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_col | input | 9 | Start column |
| cmd_bank | input | 2 | Bank select |
| mode_bl | input | 3 | Burst length code |
| mode_wr_single | input | 1 | Force writes to one location |
| burst_stop | input | 1 | Terminate the active burst |
| col_out | output | 9 | Column of the current beat |
| bank_out | output | 2 | Bank of the current burst |
| beat_valid | output | 1 | A beat is being presented |
| last_beat | output | 1 | Final beat of a fixed burst |
| mode_err | output | 1 | Last command carried a reserved length |

## Verification
Every output is one register away from its inputs. Beat 0 of a command appears one edge after the command is sampled, and beat k appears k edges later. A stop or a reserved code shows its effect, an idle output or a set error flag, one edge after it is sampled. The bench drives inputs on the falling edge, so each result is read at the falling edge that follows the edge where it is due. It walks the burst one beat per falling edge and compares each beat against an address computed from the wrap formula. The last check in each sequence looks one beat past the end to confirm that the burst has finished.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  typedef enum logic [2:0] {
    BL_ONE   = 3'b000,
    BL_TWO   = 3'b001,
    BL_FOUR  = 3'b010,
    BL_EIGHT = 3'b011,
    BL_RSV4  = 3'b100,
    BL_RSV5  = 3'b101,
    BL_RSV6  = 3'b110,
    BL_PAGE  = 3'b111
  } bl_code_e;

  function automatic logic bl_is_reserved(input logic [2:0] code);
    return (code == BL_RSV4) || (code == BL_RSV5) || (code == BL_RSV6);
  endfunction
endpackage

// File: rtl/bcg_mode_decode.sv
module bcg_mode_decode #(
  parameter int COL_W = 9,
  parameter int CNT_W = 3
) (
  input  logic [2:0]       bl_code,
  input  logic             wr_single,
  input  logic             is_write,
  output logic             reserved,
  output logic             page,
  output logic [COL_W-1:0] mask,
  output logic [CNT_W-1:0] len_m1
);
  import bcg_pkg::*;

  bl_code_e eff;

  always_comb begin
    reserved = bl_is_reserved(bl_code);
    eff      = (is_write && wr_single) ? BL_ONE : bl_code_e'(bl_code);
    page     = 1'b0;
    mask     = '0;
    len_m1   = '0;
    case (eff)
      BL_TWO:   begin mask = COL_W'(1); len_m1 = CNT_W'(1); end
      BL_FOUR:  begin mask = COL_W'(3); len_m1 = CNT_W'(3); end
      BL_EIGHT: begin mask = COL_W'(7); len_m1 = CNT_W'(7); end
      BL_PAGE:  begin mask = '1;        page   = 1'b1;      end
      default:  begin mask = '0;        len_m1 = '0;        end
    endcase
  end
endmodule

// File: rtl/bcg_wrap_step.sv
module bcg_wrap_step #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] col,
  input  logic [COL_W-1:0] mask,
  output logic [COL_W-1:0] nxt
);
  logic [COL_W-1:0] inc;
  assign inc = col + COL_W'(1);

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    assign nxt[i] = mask[i] ? inc[i] : col[i];
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W          = 9,
  parameter int BANK_W         = 2,
  parameter int MAX_FIXED_LOG2 = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [2:0]        mode_bl,
  input  logic              mode_wr_single,
  input  logic              burst_stop,
  output logic [COL_W-1:0]  col_out,
  output logic [BANK_W-1:0] bank_out,
  output logic              beat_valid,
  output logic              last_beat,
  output logic              mode_err
);
  localparam int CNT_W = MAX_FIXED_LOG2;

  logic              dec_reserved, dec_page;
  logic [COL_W-1:0]  dec_mask, step_col;
  logic [CNT_W-1:0]  dec_len_m1;

  logic [COL_W-1:0]  col_q, mask_q;
  logic [BANK_W-1:0] bank_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              act_q, last_q, page_q, err_q;

  bcg_mode_decode #(.COL_W(COL_W), .CNT_W(CNT_W)) u_dec (
    .bl_code   (mode_bl),
    .wr_single (mode_wr_single),
    .is_write  (cmd_write),
    .reserved  (dec_reserved),
    .page      (dec_page),
    .mask      (dec_mask),
    .len_m1    (dec_len_m1)
  );

  bcg_wrap_step #(.COL_W(COL_W)) u_step (
    .col  (col_q),
    .mask (mask_q),
    .nxt  (step_col)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      last_q <= 1'b0;
      err_q  <= 1'b0;
      page_q <= 1'b0;
      col_q  <= '0;
      mask_q <= '0;
      bank_q <= '0;
      cnt_q  <= '0;
    end else if (cmd_valid) begin
      if (dec_reserved) begin
        act_q  <= 1'b0;
        last_q <= 1'b0;
        err_q  <= 1'b1;
      end else begin
        act_q  <= 1'b1;
        col_q  <= cmd_col;
        bank_q <= cmd_bank;
        mask_q <= dec_mask;
        page_q <= dec_page;
        cnt_q  <= dec_len_m1;
        last_q <= !dec_page && (dec_len_m1 == '0);
        err_q  <= 1'b0;
      end
    end else if (act_q) begin
      if (burst_stop || (!page_q && cnt_q == '0)) begin
        act_q  <= 1'b0;
        last_q <= 1'b0;
      end else begin
        col_q <= step_col;
        if (!page_q) begin
          cnt_q  <= cnt_q - CNT_W'(1);
          last_q <= (cnt_q == CNT_W'(1));
        end
      end
    end
  end

  assign col_out    = col_q;
  assign bank_out   = bank_q;
  assign beat_valid = act_q;
  assign last_beat  = last_q;
  assign mode_err   = err_q;
endmodule

// File: rtl/bcg_checker.sv
module bcg_checker #(
  parameter int COL_W  = 9,
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              cmd_write,
  input logic [COL_W-1:0]  cmd_col,
  input logic [BANK_W-1:0] cmd_bank,
  input logic [2:0]        mode_bl,
  input logic              mode_wr_single,
  input logic              burst_stop,
  input logic [COL_W-1:0]  col_out,
  input logic [BANK_W-1:0] bank_out,
  input logic              beat_valid,
  input logic              last_beat,
  input logic              mode_err
);
  import bcg_pkg::*;

  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cmd_valid) && !bl_is_reserved($past(mode_bl)))
    |-> (beat_valid && col_out == $past(cmd_col) && bank_out == $past(cmd_bank)));

  p_page_nolast_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cmd_valid) && $past(mode_bl) == 3'b111
     && !($past(cmd_write) && $past(mode_wr_single))) |-> !last_beat);

  p_last_in_burst_r6: assert property (@(posedge clk) disable iff (rst)
    last_beat |-> beat_valid);

  p_single_write_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cmd_valid) && $past(cmd_write) && $past(mode_wr_single)
     && !bl_is_reserved($past(mode_bl))) |-> (beat_valid && last_beat));

  p_stop_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(burst_stop) && !$past(cmd_valid)) |-> !beat_valid);

  p_reserved_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cmd_valid) && bl_is_reserved($past(mode_bl)))
    |-> (!beat_valid && mode_err));

  p_bank_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && beat_valid && $past(beat_valid) && !$past(cmd_valid))
    |-> $stable(bank_out));
endmodule

bind burst_col_gen bcg_checker #(.COL_W(COL_W), .BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
  .cmd_col(cmd_col), .cmd_bank(cmd_bank), .mode_bl(mode_bl),
  .mode_wr_single(mode_wr_single), .burst_stop(burst_stop),
  .col_out(col_out), .bank_out(bank_out), .beat_valid(beat_valid),
  .last_beat(last_beat), .mode_err(mode_err)
);

// File: tb/burst_col_gen_test.sv
module burst_col_gen_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0, cmd_write = 1'b0, mode_wr_single = 1'b0, burst_stop = 1'b0;
  logic [8:0] cmd_col = '0;
  logic [1:0] cmd_bank = '0;
  logic [2:0] mode_bl = '0;
  logic [8:0] col_out;
  logic [1:0] bank_out;
  logic       beat_valid, last_beat, mode_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  burst_col_gen uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_col(cmd_col), .cmd_bank(cmd_bank), .mode_bl(mode_bl),
    .mode_wr_single(mode_wr_single), .burst_stop(burst_stop),
    .col_out(col_out), .bank_out(bank_out), .beat_valid(beat_valid),
    .last_beat(last_beat), .mode_err(mode_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge showing beat 0.
  task automatic start_cmd(input bit wr, input int col, input int bank,
                           input logic [2:0] bl, input bit ws, input bit stop);
    cmd_valid = 1'b1; cmd_write = wr; cmd_col = col[8:0]; cmd_bank = bank[1:0];
    mode_bl = bl; mode_wr_single = ws; burst_stop = stop;
    @(negedge clk);
    cmd_valid = 1'b0; burst_stop = 1'b0;
  endtask

  task automatic fixed_burst(input bit wr, input int col, input int bank,
                             input logic [2:0] bl, input bit ws, input int len,
                             input string req);
    start_cmd(wr, col, bank, bl, ws, 1'b0);
    for (int k = 0; k < len; k++) begin
      int exp;
      exp = (col & ~(len - 1)) | ((col + k) & (len - 1));
      chk({req, " col R4"}, col_out, exp);
      chk({req, " valid R2"}, beat_valid, 1);
      chk({req, " last R6"}, last_beat, (k == len - 1) ? 1 : 0);
      chk({req, " bank R11"}, bank_out, bank);
      @(negedge clk);
    end
    chk({req, " end R3"}, beat_valid, 0);
  endtask

  task automatic t_reset;
    chk("R1 valid", beat_valid, 0);
    chk("R1 last", last_beat, 0);
    chk("R1 err", mode_err, 0);
    chk("R1 col", col_out, 0);
  endtask

  task automatic t_lengths;
    fixed_burst(1'b0, 9'h005, 1, 3'b000, 1'b0, 1, "R3 len1");
    fixed_burst(1'b0, 9'h003, 2, 3'b001, 1'b0, 2, "R3 len2");
    fixed_burst(1'b1, 9'h006, 3, 3'b010, 1'b0, 4, "R3 len4");
    fixed_burst(1'b0, 9'h1fd, 0, 3'b011, 1'b0, 8, "R3 len8");
  endtask

  task automatic t_full_page;
    start_cmd(1'b0, 9'h1fe, 2, 3'b111, 1'b0, 1'b0);
    for (int k = 0; k < 6; k++) begin
      chk("R5 page col", col_out, (9'h1fe + k) % 512);
      chk("R5 page valid", beat_valid, 1);
      chk("R5 page no last", last_beat, 0);
      @(negedge clk);
    end
    burst_stop = 1'b1;
    @(negedge clk);
    burst_stop = 1'b0;
    chk("R9 stop page", beat_valid, 0);
    chk("R9 stop last", last_beat, 0);
  endtask

  task automatic t_write_single;
    fixed_burst(1'b1, 9'h022, 1, 3'b011, 1'b1, 1, "R7 wr single");
    fixed_burst(1'b0, 9'h022, 1, 3'b010, 1'b1, 4, "R7 rd keeps len");
    fixed_burst(1'b1, 9'h021, 1, 3'b010, 1'b0, 4, "R7 wr burst");
    fixed_burst(1'b1, 9'h0aa, 2, 3'b111, 1'b1, 1, "R7 wr single page code");
  endtask

  task automatic t_interrupt;
    start_cmd(1'b0, 9'h010, 1, 3'b011, 1'b0, 1'b0);
    chk("R8 first beat", col_out, 9'h010);
    @(negedge clk);
    chk("R8 second beat", col_out, 9'h011);
    start_cmd(1'b0, 9'h041, 2, 3'b001, 1'b0, 1'b0);
    chk("R8 restart col", col_out, 9'h041);
    chk("R8 restart bank", bank_out, 2);
    chk("R8 restart last", last_beat, 0);
    @(negedge clk);
    chk("R8 wrap col", col_out, 9'h040);
    chk("R8 wrap last", last_beat, 1);
    @(negedge clk);
    chk("R8 done", beat_valid, 0);
    start_cmd(1'b0, 9'h020, 0, 3'b111, 1'b0, 1'b0);
    start_cmd(1'b0, 9'h033, 3, 3'b000, 1'b0, 1'b1);
    chk("R8 cmd beats stop valid", beat_valid, 1);
    chk("R8 cmd beats stop col", col_out, 9'h033);
    chk("R8 cmd beats stop last", last_beat, 1);
    @(negedge clk);
    chk("R8 single done", beat_valid, 0);
  endtask

  task automatic t_stop;
    burst_stop = 1'b1;
    @(negedge clk);
    burst_stop = 1'b0;
    chk("R9 idle stop valid", beat_valid, 0);
    chk("R9 idle stop col", col_out, 9'h033);
    start_cmd(1'b0, 9'h050, 1, 3'b011, 1'b0, 1'b0);
    @(negedge clk);
    chk("R9 mid col", col_out, 9'h051);
    burst_stop = 1'b1;
    @(negedge clk);
    burst_stop = 1'b0;
    chk("R9 fixed stopped", beat_valid, 0);
    @(negedge clk);
    chk("R9 stays idle", beat_valid, 0);
  endtask

  task automatic t_reserved;
    start_cmd(1'b0, 9'h100, 0, 3'b111, 1'b0, 1'b0);
    chk("R10 page running", beat_valid, 1);
    start_cmd(1'b0, 9'h0f0, 1, 3'b100, 1'b0, 1'b0);
    chk("R10 code100 idle", beat_valid, 0);
    chk("R10 code100 err", mode_err, 1);
    chk("R10 code100 last", last_beat, 0);
    repeat (3) @(negedge clk);
    chk("R10 err held", mode_err, 1);
    chk("R10 still idle", beat_valid, 0);
    start_cmd(1'b1, 9'h0f0, 1, 3'b101, 1'b1, 1'b0);
    chk("R10 code101 write idle", beat_valid, 0);
    chk("R10 code101 err", mode_err, 1);
    start_cmd(1'b0, 9'h0f0, 1, 3'b110, 1'b0, 1'b0);
    chk("R10 code110 err", mode_err, 1);
    start_cmd(1'b0, 9'h007, 2, 3'b000, 1'b0, 1'b0);
    chk("R10 err cleared", mode_err, 0);
    chk("R10 legal beat", beat_valid, 1);
    chk("R10 legal col", col_out, 9'h007);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst = 1'b0;
    @(negedge clk);
    t_lengths;
    t_full_page;
    t_write_single;
    t_interrupt;
    t_stop;
    t_reserved;
    rst = 1'b1;
    @(negedge clk);
    t_reset;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule